// File: doc/BRIEF.md
# Stride-Doubling Prefix Sum Engine

The engine computes the running sum of a vector of `N` words. A vector is loaded in parallel on one start pulse. The engine then runs `log2(N)` lock-step steps. In each step, every word at index `j` that is at least the current stride takes the sum of itself and the word one stride lower. Words below the stride pass through unchanged. The stride starts at 1 and doubles after every step. All additions of a step happen in one cycle.

Each step reads one register bank and writes the other, and the banks swap roles after the step. No word is therefore read after it has already been updated in the same step. A mode input chosen at start selects the result type:
- Inclusive mode gives the sum up to and including each word.
- Exclusive mode gives the sum of all words strictly before each word. The loaded vector is shifted up by one index and a zero enters at index 0.

The result is presented in parallel. It stays valid from the done pulse until the next start.

Top module: `prefix_scan_engine`

## Requirements
- R1: In inclusive mode (`excl_i`=0 at start), output word `j` is the sum, modulo 2^W, of input words 0 through `j`. Word `j` occupies bits `[j*W +: W]` of `vec_i` and `vec_o`. For input 3,1,7,0,4,1,6,3 the output is 3,4,11,11,15,16,22,25.
- R2: In exclusive mode (`excl_i`=1 at start), output word 0 is zero and output word `j`>0 is the sum of input words 0 through `j-1`. For the same example input the output is 0,3,4,11,11,15,16,22.
- R3: A high `start_i` while `busy_o` is low captures `vec_i` and `excl_i`. `busy_o` is high in the following cycle.
- R4: `busy_o` stays high for exactly log2(N) cycles. `done_o` is high for one cycle, in the cycle after the last step, and `busy_o` is low in that cycle.
- R5: While idle and without a start, `vec_o` holds its value, including across changes of `vec_i`.
- R6: `start_i` while `busy_o` is high is ignored. The run in progress keeps its timing and its result.
- R7: All additions wrap modulo 2^W.
- R8: `excl_i` has no effect outside the start cycle that begins a run.
- R9: The step with stride s performs exactly N-s additions. Word 0 never changes during a run.
- R10: After reset, `busy_o` and `done_o` are low and `vec_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| excl_i | input | 1 | 1 = exclusive result, 0 = inclusive; sampled at start |
| vec_i | input | N*W | Input vector, word j at bits [j*W +: W] |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| vec_o | output | N*W | Result vector, word j at bits [j*W +: W] |

## Verification
The bench builds the engine with N=8 and W=16. This gives three steps with strides 1, 2 and 4, so the copy-through region grows from one word to four and every stride size is exercised. Words near 0xFFFF push the running sum past 2^16, which brings wraparound within reach. Random vectors in both modes are mixed with directed cases:
- the example vector
- an all-ones vector
- a start issued mid-run
- a mode flip issued mid-run
- idle hold while `vec_i` changes

// File: rtl/scan_pkg.sv
package scan_pkg;
  // stride of a given step index
  function automatic int unsigned stride_of(input int unsigned step);
    return 32'd1 << step;
  endfunction

  // whether lane j takes part in an addition at stride s
  function automatic bit lane_adds(input int unsigned j, input int unsigned s);
    return j >= s;
  endfunction
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int STEPS = 3,
  localparam int SW = (STEPS < 1) ? 1 : STEPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_en_o,
  output logic          step_en_o,
  output logic          sel_o,
  output logic [SW-1:0] step_o
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  assign load_en_o = start_i && !busy_o;
  assign step_en_o = busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sel_o  <= 1'b0;
      step_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_en_o) begin
        busy_o <= 1'b1;
        sel_o  <= 1'b0;
        step_o <= '0;
      end else if (busy_o) begin
        sel_o <= ~sel_o;
        if (step_o == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          step_o <= step_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scan_loader.sv
module scan_loader #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0][W-1:0] raw_i,
  input  logic                excl_i,
  output logic [N-1:0][W-1:0] load_o
);
  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (!excl_i)     load_o[j] = raw_i[j];
      else if (j == 0) load_o[j] = '0;
      else             load_o[j] = raw_i[j-1];
    end
  end
endmodule

// File: rtl/scan_step.sv
module scan_step #(
  parameter int N = 8,
  parameter int W = 16,
  parameter int SW = 3
) (
  input  logic [N-1:0][W-1:0] src_i,
  input  logic [SW-1:0]       step_i,
  output logic [N-1:0][W-1:0] dst_o,
  output logic [N-1:0]        add_mask_o
);
  import scan_pkg::*;

  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  int unsigned stride;
  assign stride = stride_of(32'(step_i));

  generate
    for (genvar j = 0; j < N; j++) begin : g_lane
      int unsigned partner;
      assign add_mask_o[j] = lane_adds(j, stride);
      assign partner       = add_mask_o[j] ? (j - stride) : j;
      assign dst_o[j]      = add_mask_o[j] ? wrap_add(src_i[j], src_i[partner[$clog2(N+1)-1:0]]) : src_i[j];
    end
  endgenerate
endmodule

// File: rtl/prefix_scan_engine.sv
module prefix_scan_engine #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int STEPS = $clog2(N),
  localparam int SW = (STEPS < 1) ? 1 : STEPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         excl_i,
  input  logic [N*W-1:0] vec_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N*W-1:0] vec_o
);
  logic [N-1:0][W-1:0] bank0, bank1, src, nxt, load_arr;
  logic [N-1:0]        add_mask;
  logic [SW-1:0]       step;
  logic                sel, load_en, step_en;

  scan_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .load_en_o(load_en),
    .step_en_o(step_en), .sel_o(sel), .step_o(step)
  );

  scan_loader #(.N(N), .W(W)) load_i (
    .raw_i(vec_i), .excl_i(excl_i), .load_o(load_arr)
  );

  scan_step #(.N(N), .W(W), .SW(SW)) step_i (
    .src_i(src), .step_i(step), .dst_o(nxt), .add_mask_o(add_mask)
  );

  assign src   = sel ? bank1 : bank0;
  assign vec_o = src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank0 <= '0;
      bank1 <= '0;
    end else if (load_en) begin
      bank0 <= load_arr;
    end else if (step_en) begin
      if (sel) bank0 <= nxt;
      else     bank1 <= nxt;
    end
  end
endmodule

// File: rtl/scan_engine_chk.sv
module scan_engine_chk #(
  parameter int N = 8,
  parameter int W = 16,
  parameter int SW = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         excl_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [N*W-1:0] vec_o,
  input logic [N-1:0] add_mask,
  input logic [SW-1:0] step
);
  localparam int STEPS = $clog2(N);

  logic [7:0] run_len;
  logic       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      mode_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      run_len <= '0;
      mode_q  <= excl_i;
    end else if (busy_o) begin
      run_len <= run_len + 1'b1;
    end
  end

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == 8'(STEPS)));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(vec_o));
  a_r6_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && run_len < 8'(STEPS - 1)) |=> busy_o);
  a_r9_word0_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(vec_o[W-1:0]));
  a_r9_add_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(add_mask) == N - (1 << step)));
  a_r2_excl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q) |-> (vec_o[W-1:0] == '0));
endmodule

bind prefix_scan_engine scan_engine_chk #(.N(N), .W(W), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .excl_i(excl_i),
  .busy_o(busy_o), .done_o(done_o), .vec_o(vec_o),
  .add_mask(add_mask), .step(step)
);

// File: tb/prefix_scan_engine_tb_top.sv
module prefix_scan_engine_tb_top;
  localparam int N = 8;
  localparam int W = 16;
  localparam int STEPS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic excl_i = 1'b0;
  logic [N*W-1:0] vec_i = '0;
  logic busy_o, done_o;
  logic [N*W-1:0] vec_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prefix_scan_engine #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .excl_i(excl_i),
    .vec_i(vec_i), .busy_o(busy_o), .done_o(done_o), .vec_o(vec_o)
  );

  function automatic logic [N*W-1:0] model(input logic [N*W-1:0] v, input bit excl);
    logic [N*W-1:0] r;
    logic [W-1:0] acc;
    acc = '0;
    for (int j = 0; j < N; j++) begin
      if (excl) begin
        r[j*W +: W] = acc;
        acc = acc + v[j*W +: W];
      end else begin
        acc = acc + v[j*W +: W];
        r[j*W +: W] = acc;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // runs one vector; optional disturbance in the middle of the run
  task automatic run(input logic [N*W-1:0] v, input bit excl, input string req,
                     input bit poke_start, input bit poke_mode);
    logic [N*W-1:0] exp;
    int busy_cycles;
    int guard;
    exp = model(v, excl);
    @(negedge clk);
    vec_i = v; excl_i = excl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R3 busy after start", {127'd0, busy_o}, 1);
    busy_cycles = 1;
    if (poke_start) begin
      start_i = 1'b1;
      vec_i = ~v;
    end
    if (poke_mode) excl_i = ~excl;
    guard = 0;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && guard < 50) begin
      if (busy_o) busy_cycles++;
      guard++;
      @(negedge clk);
    end
    check(done_o && !busy_o, "R4 done with busy low", {126'd0, done_o, busy_o}, 2);
    check(busy_cycles == STEPS, "R4 busy length", 128'(busy_cycles), 128'(STEPS));
    check(vec_o == exp, req, vec_o, exp);
    @(negedge clk);
    check(!done_o, "R4 done one cycle", {127'd0, done_o}, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N*W-1:0] ex, held;
    void'($urandom(32'd4242));
    ex = {16'd3, 16'd6, 16'd1, 16'd4, 16'd0, 16'd7, 16'd1, 16'd3};
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && vec_o == '0, "R10 reset state", vec_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && vec_o == '0, "R10 after release", vec_o, '0);

    run(ex, 1'b0, "R1 inclusive example", 1'b0, 1'b0);
    check(vec_o == {16'd25,16'd22,16'd16,16'd15,16'd11,16'd11,16'd4,16'd3},
          "R1 literal", vec_o, {16'd25,16'd22,16'd16,16'd15,16'd11,16'd11,16'd4,16'd3});
    run(ex, 1'b1, "R2 exclusive example", 1'b0, 1'b0);
    check(vec_o == {16'd22,16'd16,16'd15,16'd11,16'd11,16'd4,16'd3,16'd0},
          "R2 literal", vec_o, {16'd22,16'd16,16'd15,16'd11,16'd11,16'd4,16'd3,16'd0});

    run({N{16'hFFFF}}, 1'b0, "R7 wrap inclusive", 1'b0, 1'b0);
    run({N{16'hF000}}, 1'b1, "R7 wrap exclusive", 1'b0, 1'b0);

    run(ex, 1'b0, "R6 start while busy ignored", 1'b1, 1'b0);
    run(ex, 1'b1, "R8 mode flip mid-run ignored", 1'b0, 1'b1);

    // R5: hold while idle
    held = vec_o;
    vec_i = '1; excl_i = 1'b0;
    repeat (4) @(negedge clk);
    check(vec_o == held && !busy_o, "R5 idle hold", vec_o, held);

    // R9: word 0 equals first input in inclusive mode
    run({112'd0, 16'h1234}, 1'b0, "R9 word0 copy", 1'b0, 1'b0);

    for (int k = 0; k < 20; k++) begin
      logic [N*W-1:0] rv;
      for (int j = 0; j < N; j++) rv[j*W +: W] = W'($urandom);
      run(rv, k[0], k[0] ? "R2 random" : "R1 random", 1'b0, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule